// File: doc/BRIEF.md
# Double-Buffered Converter Register Controller

This block is the control logic that sits between a serial bus receiver and a single digital-to-analog converter channel. It holds two registers: a staging register that receives new codes, and an output register whose contents drive the converter. It also holds a power-down flag. The bus receiver hands it a one-cycle strobe for each completed 24-bit word, together with the 4-bit command and the data code of that word, and a level that is high while a word is being shifted in.

An active-low load pin gives a second path to the output register. It is synchronised into the clock domain. A falling edge copies the staging register into the output register, but only if a complete word is waiting that has not yet been applied, and only while no word is being shifted in. The pin held low always brings the channel out of power-down. If the pin is low at the moment a word completes, the word's command runs, the output register is updated at once, and any power-down request in that word is dropped.

Top module: `dac_buffer_ctrl`

## Requirements
- R1: After reset both registers hold zero scale and `powerDown` is 0. With parameter `RESET_MID`=1, both registers instead reset to midscale (only the MSB set).
- R2: A word with command 4'b0000 loads `wordData` into the staging register and leaves `dacCode` and `powerDown` unchanged.
- R3: A word with command 4'b0001 copies the staging register to `dacCode` and clears `powerDown`, one clock after `wordDone`.
- R4: A word with command 4'b0011 loads `wordData` into the staging register and drives that same value onto `dacCode` one clock after `wordDone`, clearing `powerDown`.
- R5: A word with command 4'b0100 sets `powerDown`, ignores `wordData`, and leaves both registers unchanged.
- R6: Command 4'b1111 is a no-op. Every code other than 0000, 0001, 0011, 0100 and 1111 is reserved: it changes neither register nor `powerDown`, and it does not count as a complete word for R7.
- R7: A falling edge on the synchronised `loadN` copies the staging register to `dacCode` and clears `powerDown`, but only if a valid word has completed since the last update of `dacCode`. Otherwise a falling edge leaves `dacCode` unchanged.
- R8: While the synchronised `loadN` is low, `powerDown` is cleared, whether or not the bus is active.
- R9: If the synchronised `loadN` is low when a valid word completes, the command runs, `dacCode` then takes the resulting staging value, and a power-down command in that word has no effect.
- R10: A falling edge on `loadN` while `xferBusy` is high updates nothing. A pulse during a partial word only powers the channel up, and the output stays the same after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordDone | input | 1 | One-cycle strobe: a complete word is available |
| wordCmd | input | 4 | Command field of the completed word |
| wordData | input | DATA_W | Data code of the completed word |
| xferBusy | input | 1 | High while a word is being shifted in |
| loadN | input | 1 | Asynchronous active-low load pin |
| dacCode | output | DATA_W | Output register contents driving the converter |
| powerDown | output | 1 | Channel is powered down |

## Verification
The bench goes after the interactions between the load pin and the bus. A load edge with no complete word waiting must not move the output. A design without the waiting-word flag would show a stale or repeated copy there. A pulse while `xferBusy` is high must power the channel up but leave the code alone. A design that ignores the busy level would apply the staging register early. A power-down word that completes with the pin low must leave the channel powered. A design that skipped that veto would show `powerDown` set. Reserved codes mixed into a random stream must leave everything unchanged, and so must load edges that arrive after an update has already taken place.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

  typedef enum logic [3:0] {
    CMD_WRITE  = 4'b0000,
    CMD_UPDATE = 4'b0001,
    CMD_WRUPD  = 4'b0011,
    CMD_PWRDN  = 4'b0100,
    CMD_NOP    = 4'b1111
  } dacCmdE;

  // Strobes from control to the register datapath
  typedef struct packed {
    logic loadIn;       // capture word data into staging register
    logic loadDac;      // update output register
    logic dacFromWord;  // output register takes word data directly
    logic setPd;        // enter power-down
    logic clrPd;        // leave power-down
  } ctlStrobeT;

  function automatic logic cmdValid(input logic [3:0] c);
    return (c == CMD_WRITE) || (c == CMD_UPDATE) || (c == CMD_WRUPD) ||
           (c == CMD_PWRDN) || (c == CMD_NOP);
  endfunction

endpackage

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic loadN,
  output logic loadLow,
  output logic loadFall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] syncChain;
  logic          prevLevel;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= loadN;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[LAST-1:0], loadN};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLevel <= 1'b1;
    else       prevLevel <= syncChain[LAST];
  end

  assign loadLow  = ~syncChain[LAST];
  assign loadFall = prevLevel & ~syncChain[LAST];
endmodule

// File: rtl/dac_ctrl_fsm.sv
module dac_ctrl_fsm
  import dac_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wordDone,
  input  logic [3:0] wordCmd,
  input  logic      xferBusy,
  input  logic      loadLow,
  input  logic      loadFall,
  output ctlStrobeT strb
);
  logic pending;
  logic validWord, cmdWrites, cmdUpdates, cmdPd, pinEdgeUpd;

  always_comb begin
    validWord  = wordDone && cmdValid(wordCmd);
    cmdWrites  = validWord && ((wordCmd == CMD_WRITE) || (wordCmd == CMD_WRUPD));
    cmdUpdates = validWord && ((wordCmd == CMD_UPDATE) || (wordCmd == CMD_WRUPD) || loadLow);
    cmdPd      = validWord && (wordCmd == CMD_PWRDN) && !loadLow;
    pinEdgeUpd = loadFall && pending && !xferBusy && !wordDone;

    strb.loadIn      = cmdWrites;
    strb.loadDac     = cmdUpdates || pinEdgeUpd;
    strb.dacFromWord = cmdWrites;
    strb.setPd       = cmdPd;
    strb.clrPd       = loadLow || cmdUpdates || pinEdgeUpd;
  end

  // A complete word waits here until some update consumes it
  always_ff @(posedge clk) begin
    if (!rstN)             pending <= 1'b0;
    else if (strb.loadDac) pending <= 1'b0;
    else if (validWord)    pending <= 1'b1;
  end
endmodule

// File: rtl/dac_regs.sv
module dac_regs
  import dac_ctrl_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strb,
  input  logic [DATA_W-1:0] wordData,
  output logic [DATA_W-1:0] dacCode,
  output logic              powerDown
);
  localparam logic [DATA_W-1:0] RST_CODE =
    RESET_MID ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  logic [DATA_W-1:0] stageReg;
  logic [DATA_W-1:0] dacReg;
  logic              pdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageReg <= RST_CODE;
      dacReg   <= RST_CODE;
    end else begin
      if (strb.loadIn)  stageReg <= wordData;
      if (strb.loadDac) dacReg   <= strb.dacFromWord ? wordData : stageReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           pdReg <= 1'b0;
    else if (strb.clrPd) pdReg <= 1'b0;
    else if (strb.setPd) pdReg <= 1'b1;
  end

  assign dacCode   = dacReg;
  assign powerDown = pdReg;
endmodule

// File: rtl/dac_buffer_ctrl.sv
module dac_buffer_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit RESET_MID   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordDone,
  input  logic [3:0]        wordCmd,
  input  logic [DATA_W-1:0] wordData,
  input  logic              xferBusy,
  input  logic              loadN,
  output logic [DATA_W-1:0] dacCode,
  output logic              powerDown
);
  logic      loadLow, loadFall;
  ctlStrobeT strb;

  dac_load_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .loadN(loadN),
    .loadLow(loadLow), .loadFall(loadFall)
  );

  dac_ctrl_fsm u_ctl (
    .clk(clk), .rstN(rstN), .wordDone(wordDone), .wordCmd(wordCmd),
    .xferBusy(xferBusy), .loadLow(loadLow), .loadFall(loadFall), .strb(strb)
  );

  dac_regs #(.DATA_W(DATA_W), .RESET_MID(RESET_MID)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wordData(wordData),
    .dacCode(dacCode), .powerDown(powerDown)
  );

  p_write_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && wordCmd == CMD_WRITE && !loadLow) |=> $stable(dacCode) && $stable(powerDown));

  p_update_pwrup_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && wordCmd == CMD_UPDATE) |=> !powerDown);

  p_wrupd_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && wordCmd == CMD_WRUPD) |=> (dacCode == $past(wordData)) && !powerDown);

  p_pd_enter_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && wordCmd == CMD_PWRDN && !loadLow) |=> powerDown && $stable(dacCode));

  p_reserved_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && !cmdValid(wordCmd) && !loadLow) |=> $stable(dacCode) && $stable(powerDown));

  p_pin_pwrup_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadLow |=> !powerDown);

  p_pd_veto_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && wordCmd == CMD_PWRDN && loadLow) |=> !powerDown);

  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    (xferBusy && !wordDone) |=> $stable(dacCode));
endmodule

// File: tb/dac_buffer_ctrl_test.sv
module dac_buffer_ctrl_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wordDone = 1'b0;
  logic [3:0]    wordCmd = 4'h0;
  logic [DW-1:0] wordData = '0;
  logic          xferBusy = 1'b0;
  logic          loadN = 1'b1;
  logic [DW-1:0] dacCode;
  logic          powerDown;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] mIn, mDac;
  logic          mPd, mPend;

  always #4 clk = ~clk;

  dac_buffer_ctrl #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .wordDone(wordDone), .wordCmd(wordCmd),
    .wordData(wordData), .xferBusy(xferBusy), .loadN(loadN),
    .dacCode(dacCode), .powerDown(powerDown)
  );

  function automatic bit isValid(input logic [3:0] c);
    return c == 4'b0000 || c == 4'b0001 || c == 4'b0011 || c == 4'b0100 || c == 4'b1111;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req);
    checks++;
    if (dacCode !== mDac || powerDown !== mPd) begin
      errors++;
      $display("FAIL %s: dacCode=%h powerDown=%b expected dacCode=%h powerDown=%b",
               req, dacCode, powerDown, mDac, mPd);
    end
  endtask

  // model of a load-pin falling edge
  task automatic modelFall(input bit busy);
    mPd = 1'b0;
    if (!busy && mPend) begin
      mDac = mIn;
      mPend = 1'b0;
    end
  endtask

  task automatic sendWord(input logic [3:0] c, input logic [DW-1:0] d, input bit pinLow);
    if (pinLow) begin
      loadN = 1'b0;
      modelFall(1'b0);
      cyc(6);
    end
    wordCmd = c; wordData = d; wordDone = 1'b1;
    cyc(1);
    wordDone = 1'b0;
    if (isValid(c)) begin
      if (c == 4'b0000 || c == 4'b0011) mIn = d;
      if (c == 4'b0001 || c == 4'b0011 || pinLow) begin
        mDac = mIn; mPd = 1'b0; mPend = 1'b0;
      end else begin
        mPend = 1'b1;
      end
      if (c == 4'b0100 && !pinLow) mPd = 1'b1;
    end
    if (pinLow) begin
      check("R9 word with pin low");
      loadN = 1'b1;
      cyc(6);
    end
  endtask

  task automatic pinPulse(input bit busy);
    xferBusy = busy;
    cyc(1);
    loadN = 1'b0;
    modelFall(busy);
    cyc(6);
    loadN = 1'b1;
    cyc(6);
    xferBusy = 1'b0;
    cyc(1);
  endtask

  initial begin
    mIn = '0; mDac = '0; mPd = 1'b0; mPend = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    check("R1 reset state zero scale");

    sendWord(4'b0000, 16'h1234, 0); check("R2 write staging only");
    sendWord(4'b0001, 16'hFFFF, 0); check("R3 update copies staging");
    sendWord(4'b0100, 16'hAAAA, 0); check("R5 power-down keeps registers");
    sendWord(4'b0011, 16'hBEEF, 0); check("R4 write and update, power up");
    sendWord(4'b0000, 16'h0F0F, 0); check("R2 write staging only again");
    sendWord(4'b0101, 16'h7777, 0); check("R6 reserved code ignored");
    sendWord(4'b1111, 16'h5555, 0); check("R6 no-op");
    pinPulse(0);                    check("R7 pin edge applies pending word");
    pinPulse(0);                    check("R7 pin edge with nothing pending");
    sendWord(4'b0100, 16'h0000, 0); check("R5 power-down again");
    sendWord(4'b0000, 16'hC001, 0); check("R2 write while powered down");
    pinPulse(1);                    check("R10 pulse during transfer: power up only");
    check("R8 pin low cleared power-down");
    pinPulse(0);                    check("R7 pending word applied after transfer");
    sendWord(4'b0000, 16'h8001, 0);
    sendWord(4'b0100, 16'h1111, 1); check("R9 power-down vetoed, output updated");
    sendWord(4'b0011, 16'h0000, 0); check("R4 write and update zero");
    sendWord(4'b1111, 16'h0000, 0);
    pinPulse(0);                    check("R7 no-op word then pin edge");

    for (int i = 0; i < 400; i++) begin
      int mode;
      logic [3:0] c;
      logic [DW-1:0] d;
      mode = $urandom_range(0, 5);
      c = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) begin
        case ($urandom_range(0, 4))
          0: c = 4'b0000; 1: c = 4'b0001; 2: c = 4'b0011;
          3: c = 4'b0100; default: c = 4'b1111;
        endcase
      end
      d = DW'($urandom);
      case (mode)
        0, 1: begin sendWord(c, d, 0); check("R2 R3 R4 R5 R6 random word"); end
        2:    begin sendWord(c, d, 1); check("R9 random word pin low"); end
        3:    begin pinPulse(0); check("R7 random pin edge"); end
        4:    begin pinPulse(1); check("R10 random pulse during transfer"); end
        default: begin sendWord(4'b0100, d, 0); check("R5 random power-down"); end
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule